// File: doc/BRIEF.md
# Glitch Detector Supervisor Registers

This block sits on an APB bus and supervises four external voltage/clock glitch detectors. It decides whether the detectors are armed. The armed decision combines a fused arm bit with two software override words, and each override acts only on an exact 16-bit key value. It also picks the sensitivity driven to each detector. That value is either the fused default or a software value, and the software value is used only when a select byte carries a key and the value's inverse copy checks out.

Detector firings pass through a two-flop synchronizer. They are then collected in sticky status bits that software clears by writing ones. Software can also fake a firing through a self-clearing force word. While the block is armed, any firing or forced firing produces a one-cycle reset request toward the power-domain reset controller. It also sets a sticky reason flag that only the block's own reset clears. A lock byte, once written nonzero, freezes the configuration words. Only secure bus accesses have any effect.

Top module: `glitch_guard_regs`

## Requirements
- R1: After reset the ARM word (offset 0x00) reads 0x5BAD. DISARM (0x04), SENSITIVITY (0x08), LOCK (0x0C) and STATUS (0x10) read 0. `armed` follows `otp_arm`, `sens_out` equals `otp_sens`, and `glitch_reason` is 0.
- R2: Any ARM value other than 0x5BAD makes `armed` 1, whatever `otp_arm` and DISARM hold.
- R3: When ARM is 0x5BAD, `armed` equals `otp_arm` unless DISARM holds exactly 0xDCAF, in which case `armed` is 0. DISARM has no effect while ARM forces arming.
- R4: The software sensitivity is used only when SENSITIVITY bits [31:24] equal 0xDE. Otherwise every detector gets its `otp_sens` field.
- R5: Detector i has its value at SENSITIVITY bits [2i+1:2i] and its inverse at bits [2i+9:2i+8]. When the select key is present, detector i's `sens_out` field takes the register value only if the inverse is the bitwise complement of the value. Otherwise that field falls back to the `otp_sens` field.
- R6: Once a nonzero value is written to LOCK bits [7:0], later writes to ARM, DISARM, SENSITIVITY and LOCK change nothing. STATUS clears and FORCE writes still work.
- R7: A detector input held high reaches STATUS bit i (offset 0x10, bit i = detector i) through a two-flop synchronizer. The bit stays set after the input falls, and bits from separate events accumulate.
- R8: Writing a one to a STATUS bit clears it, unless its synchronized detector input is still high, in which case the bit stays set.
- R9: Writing ones to FORCE (0x14, bit i = detector i) sets the matching STATUS bits. FORCE always reads 0.
- R10: While armed, the first cycle of (any synchronized trigger or FORCE write) produces a one-cycle `pd_reset_req` pulse one clock later. A held trigger gives exactly one pulse, and nothing pulses while disarmed.
- R11: `glitch_reason` is set together with a reset request and stays 1 until `rst_n` is asserted.
- R12: An access with `pprot[1]`=1 (non-secure) completes with `pslverr`=1, reads 0 and changes no state.
- R13: Unimplemented bits and unmapped offsets read 0. SENSITIVITY bits [23:16] read 0 after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| pprot | input | 3 | APB protection; bit 1 set = non-secure |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error for non-secure accesses |
| otp_arm | input | 1 | Fused arm default |
| otp_sens | input | NDET*SW | Fused sensitivity defaults, detector 0 lowest |
| det_trig | input | NDET | Asynchronous detector firing inputs |
| sens_out | output | NDET*SW | Sensitivity applied to each detector |
| armed | output | 1 | Effective armed state |
| pd_reset_req | output | 1 | One-cycle power-domain reset request |
| glitch_reason | output | 1 | Sticky flag: a glitch reset was requested |

## Verification
The arming logic is driven with the idle key, off-by-one-bit disarm keys and forced arm values, with the fused bit both set and clear. This separates exact key matching from plain nonzero tests and shows the override priority. Sensitivity is applied with the select key missing, with a fully consistent value/inverse pair, and with one corrupted inverse field. The last case shows that the fallback happens per detector and not for all four. Triggers are sent as short pulses, as overlapping sets, as inputs held through a clear, and as forced writes, both armed and disarmed. This separates sticky accumulation, set-over-clear priority, edge-based pulse generation and the arm gating of the reset request.

// File: rtl/glitch_guard_regs.sv
module glitch_guard_regs #(
  parameter int          NDET       = 4,
  parameter int          SW         = 2,
  parameter int          ADDR_W     = 5,
  parameter logic [15:0] ARM_IDLE   = 16'h5BAD,
  parameter logic [15:0] DISARM_KEY = 16'hDCAF,
  parameter logic [7:0]  SENS_KEY   = 8'hDE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [31:0]          pwdata,
  input  logic [2:0]           pprot,
  output logic [31:0]          prdata,
  output logic                 pready,
  output logic                 pslverr,
  input  logic                 otp_arm,
  input  logic [NDET*SW-1:0]   otp_sens,
  input  logic [NDET-1:0]      det_trig,
  output logic [NDET*SW-1:0]   sens_out,
  output logic                 armed,
  output logic                 pd_reset_req,
  output logic                 glitch_reason
);
  localparam int VW = NDET * SW;
  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] W_ARM  = IW'(0);
  localparam logic [IW-1:0] W_DIS  = IW'(1);
  localparam logic [IW-1:0] W_SENS = IW'(2);
  localparam logic [IW-1:0] W_LOCK = IW'(3);
  localparam logic [IW-1:0] W_STAT = IW'(4);
  localparam logic [IW-1:0] W_FRC  = IW'(5);

  logic [15:0]     arm_q, disarm_q;
  logic [VW-1:0]   sval_q, sinv_q;
  logic [7:0]      ssel_q, lock_q;
  logic [NDET-1:0] status_q, sync1_q, sync2_q;
  logic            ev_q, req_q, reason_q;

  wire [IW-1:0] widx   = paddr[ADDR_W-1:2];
  wire          secure = ~pprot[1];
  wire          wr     = psel & penable & pwrite & secure;
  wire          cfg_wr = wr & (lock_q == 8'd0);

  wire [NDET-1:0] clr_bits   = (wr && widx == W_STAT) ? pwdata[NDET-1:0] : '0;
  wire [NDET-1:0] force_bits = (wr && widx == W_FRC)  ? pwdata[NDET-1:0] : '0;
  wire [NDET-1:0] hits       = sync2_q | force_bits;
  wire            ev         = armed & (|hits);

  assign armed = (arm_q != ARM_IDLE) | (otp_arm & (disarm_q != DISARM_KEY));
  assign pready = 1'b1;
  assign pslverr = psel & penable & ~secure;
  assign pd_reset_req = req_q;
  assign glitch_reason = reason_q;

  wire use_sw = (ssel_q == SENS_KEY);
  for (genvar i = 0; i < NDET; i++) begin : g_sens
    wire [SW-1:0] v  = sval_q[i*SW +: SW];
    wire          ok = use_sw && (sinv_q[i*SW +: SW] == ~v);
    assign sens_out[i*SW +: SW] = ok ? v : otp_sens[i*SW +: SW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q    <= ARM_IDLE;
      disarm_q <= '0;
      sval_q   <= '0;
      sinv_q   <= '0;
      ssel_q   <= '0;
      lock_q   <= '0;
    end else if (cfg_wr) begin
      case (widx)
        W_ARM:  arm_q <= pwdata[15:0];
        W_DIS:  disarm_q <= pwdata[15:0];
        W_SENS: begin
          sval_q <= pwdata[VW-1:0];
          sinv_q <= pwdata[2*VW-1:VW];
          ssel_q <= pwdata[31:24];
        end
        W_LOCK: lock_q <= pwdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q  <= '0;
      sync2_q  <= '0;
      status_q <= '0;
      ev_q     <= 1'b0;
      req_q    <= 1'b0;
      reason_q <= 1'b0;
    end else begin
      sync1_q  <= det_trig;
      sync2_q  <= sync1_q;
      status_q <= (status_q & ~clr_bits) | hits;
      ev_q     <= ev;
      req_q    <= ev & ~ev_q;
      if (ev & ~ev_q) reason_q <= 1'b1;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && secure) begin
      case (widx)
        W_ARM:  prdata[15:0] = arm_q;
        W_DIS:  prdata[15:0] = disarm_q;
        W_SENS: begin
          prdata[VW-1:0]    = sval_q;
          prdata[2*VW-1:VW] = sinv_q;
          prdata[31:24]     = ssel_q;
        end
        W_LOCK: prdata[7:0] = lock_q;
        W_STAT: prdata[NDET-1:0] = status_q;
        default: ;
      endcase
    end
  end

  // R10
  reset_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_reset_req |=> !pd_reset_req);
  // R10
  reset_pulse_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_reset_req |-> $past(armed));
  // R11
  reason_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(glitch_reason));
  // R11
  reason_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_reset_req |-> glitch_reason);
  // R6
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != 8'd0) |=> ($stable(arm_q) && $stable(disarm_q) && $stable(sval_q)
                          && $stable(sinv_q) && $stable(ssel_q) && $stable(lock_q)));
  // R12
  nonsecure_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pprot[1]) |=> ($stable(arm_q) && $stable(disarm_q)
                          && $stable(lock_q) && $stable(ssel_q)));
  // R7
  status_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & $past(sync2_q)) == $past(sync2_q)));
endmodule

// File: tb/test_glitch_guard_regs.sv
module test_glitch_guard_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [2:0]  pprot = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        otp_arm = 0;
  logic [7:0]  otp_sens = 8'h1B;
  logic [3:0]  det_trig = '0;
  logic [7:0]  sens_out;
  logic        armed, pd_reset_req, glitch_reason;

  int checks = 0, failures = 0, pulses = 0;

  glitch_guard_regs i_glitch_guard_regs (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .pprot,
    .prdata, .pready, .pslverr, .otp_arm, .otp_sens, .det_trig,
    .sens_out, .armed, .pd_reset_req, .glitch_reason);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (pd_reset_req) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [4:0] a, input logic [31:0] d, input bit w, input bit ns,
                      output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d; pprot = ns ? 3'b010 : 3'b000;
    @(negedge clk);
    penable = 1;
    #1 rd = prdata; err = pslverr;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] r; logic e;
    xfer(a, d, 1'b1, 1'b0, r, e);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    logic e;
    xfer(a, 32'h0, 1'b0, 1'b0, d, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; idle(2); rst_n = 1; idle(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(5'h00, d); chk("R1 arm reset", d, 32'h5BAD);
    rd(5'h04, d); chk("R1 disarm reset", d, 0);
    rd(5'h08, d); chk("R1 sens reset", d, 0);
    rd(5'h0C, d); chk("R1 lock reset", d, 0);
    rd(5'h10, d); chk("R1 status reset", d, 0);
    chk("R1 armed follows otp", armed, 0);
    chk("R1 sens_out otp", sens_out, 8'h1B);
    chk("R1 reason clear", glitch_reason, 0);
  endtask

  task automatic t_arming();
    otp_arm = 1; idle(1);
    chk("R3 otp arms", armed, 1);
    wr(5'h04, 32'hDCAF); chk("R3 disarm key", armed, 0);
    wr(5'h04, 32'hDCAE); chk("R3 near key ignored", armed, 1);
    wr(5'h04, 32'hDCAF); wr(5'h00, 32'h0000);
    chk("R2 arm beats disarm", armed, 1);
    wr(5'h00, 32'h5BAD); chk("R3 idle arm restores disarm", armed, 0);
    otp_arm = 0; wr(5'h04, 0); wr(5'h00, 32'h1234);
    chk("R2 arm without otp", armed, 1);
    wr(5'h00, 32'h5BAD); chk("R2 idle key disarmed", armed, 0);
  endtask

  task automatic t_sens();
    logic [31:0] d;
    wr(5'h08, 32'h00_00_1B_E4); chk("R4 no key uses otp", sens_out, 8'h1B);
    wr(5'h08, 32'hDE_00_1B_E4); chk("R4 key uses register", sens_out, 8'hE4);
    wr(5'h08, 32'hDF_00_1B_E4); chk("R4 wrong key uses otp", sens_out, 8'h1B);
    wr(5'h08, 32'hDE_00_2B_E4); chk("R5 det2 inverse bad falls back", sens_out, 8'hD4);
    rd(5'h08, d); chk("R5 readback", d, 32'hDE002BE4);
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, d); chk("R13 unused sens bits", d, 32'hFF00FFFF);
    wr(5'h08, 0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    int p0 = pulses;
    det_trig = 4'b0101; idle(3); det_trig = 0; idle(4);
    rd(5'h10, d); chk("R7 status captured", d, 4'h5);
    det_trig = 4'b1000; idle(3); det_trig = 0; idle(4);
    rd(5'h10, d); chk("R7 status accumulates", d, 4'hD);
    wr(5'h10, 32'h4); rd(5'h10, d); chk("R8 w1c clears bit", d, 4'h9);
    det_trig = 4'b0001; idle(4);
    wr(5'h10, 32'h1); rd(5'h10, d); chk("R8 held input resets bit", d, 4'h9);
    det_trig = 0; idle(4);
    wr(5'h10, 32'hF); rd(5'h10, d); chk("R8 clear all", d, 0);
    wr(5'h14, 32'h6); rd(5'h10, d); chk("R9 force sets status", d, 4'h6);
    rd(5'h14, d); chk("R9 force reads zero", d, 0);
    wr(5'h10, 32'hF);
    chk("R10 no pulse disarmed", pulses - p0, 0);
    chk("R11 no reason disarmed", glitch_reason, 0);
  endtask

  task automatic t_armed_reset();
    int p0;
    wr(5'h00, 0); idle(2);
    p0 = pulses;
    chk("R10 no pulse on arming", pulses - p0, 0);
    det_trig = 4'b0010; idle(10);
    chk("R10 one pulse for held trigger", pulses - p0, 1);
    chk("R11 reason set", glitch_reason, 1);
    det_trig = 0; idle(4); wr(5'h10, 32'hF);
    p0 = pulses;
    wr(5'h14, 32'h1); idle(1);
    chk("R10 force pulses when armed", pulses - p0, 1);
    wr(5'h10, 32'hF); wr(5'h00, 32'h5BAD); idle(5);
    chk("R11 reason stays after disarm", glitch_reason, 1);
  endtask

  task automatic t_nonsecure();
    logic [31:0] d; logic e;
    xfer(5'h00, 32'h0, 1'b1, 1'b1, d, e); chk("R12 ns write err", e, 1);
    rd(5'h00, d); chk("R12 ns write ignored", d, 32'h5BAD);
    xfer(5'h00, 0, 1'b0, 1'b1, d, e);
    chk("R12 ns read zero", d, 0); chk("R12 ns read err", e, 1);
    xfer(5'h14, 32'hF, 1'b1, 1'b1, d, e);
    rd(5'h10, d); chk("R12 ns force ignored", d, 0);
    xfer(5'h0C, 32'h1, 1'b1, 1'b1, d, e);
    rd(5'h0C, d); chk("R12 ns lock ignored", d, 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(5'h0C, 32'h01);
    wr(5'h00, 32'h0); rd(5'h00, d); chk("R6 arm frozen", d, 32'h5BAD);
    chk("R6 armed unchanged", armed, 0);
    wr(5'h08, 32'hDE00FF00); rd(5'h08, d); chk("R6 sens frozen", d, 0);
    wr(5'h04, 32'hDCAF); rd(5'h04, d); chk("R6 disarm frozen", d, 0);
    wr(5'h0C, 32'h00); rd(5'h0C, d); chk("R6 lock sticky", d, 1);
    wr(5'h14, 32'h8); rd(5'h10, d); chk("R6 force works locked", d, 4'h8);
    wr(5'h10, 32'h8); rd(5'h10, d); chk("R6 clear works locked", d, 0);
  endtask

  task automatic t_unmapped_and_rereset();
    logic [31:0] d;
    rd(5'h18, d); chk("R13 unmapped reads zero", d, 0);
    do_reset();
    chk("R11 reason cleared by reset", glitch_reason, 0);
    rd(5'h0C, d); chk("R1 lock cleared by reset", d, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    t_reset();
    t_arming();
    t_sens();
    t_status();
    t_armed_reset();
    t_nonsecure();
    t_lock();
    t_unmapped_and_rereset();
    finish_run();
  end
endmodule